// File: doc/BRIEF.md
# Priority Pin Crossbar

This block connects a fixed list of thirty peripheral signals to a bank of general-purpose pins (32 by default, seen as four 8-bit ports). Three 8-bit configuration words and a three-wire SPI flag decide which signals are wanted. The block then packs only the wanted signals onto consecutive pins. It starts at pin 0 and walks the signals from highest to lowest priority. Turning one peripheral on or off therefore moves the pins of every peripheral below it.

The allocation is purely combinational. For every pin it reports the code of the signal placed there, or the value 31 when the pin is free. For every signal it reports the pin index it received and a valid flag. It also does the routing. Each pin is driven from the output of the peripheral that owns it, and each peripheral input reads the pin it was given. Free pins idle high, and a peripheral input with no pin reads 1.

Top module: `xbar_top`

## Requirements
- R1: Every signal with a pin sits at the index equal to the number of enabled signals that come before it in priority order. Valid signals therefore fill pins 0, 1, 2 and so on with no gaps.
- R2: When the first UART is enabled, its transmit signal (code 0) is on pin 0 and its receive signal (code 1) is on pin 1, whatever else is enabled.
- R3: The signal codes in priority order are:
  - 0 and 1: first UART TX and RX
  - 2 to 5: SPI clock, MISO, MOSI and slave select
  - 6 and 7: I2C data and clock
  - 8 and 9: second UART TX and RX
  - 10 to 15: capture/compare channels 0 to 5
  - 16: counter clock input
  - 17 and 18: comparators 0 and 1
  - 19: timer 0
  - 20: interrupt 0
  - 21: timer 1
  - 22: interrupt 1
  - 23 and 24: timer 2 and its external input
  - 25 and 26: timer 4 and its external input
  - 27: clock output
  - 28 and 29: conversion starts 0 and 2
- R4: The bits of cfgA (word A) enable signals as follows:
  - bit 0: I2C
  - bit 1: SPI
  - bit 2: first UART
  - bits [5:3]: capture/compare channel count
  - bit 6: counter clock input
  - bit 7: comparator 0
- R5: The bits of cfgB (word B) enable signals as follows:
  - bit 0: comparator 1
  - bit 1: timer 0
  - bit 2: interrupt 0
  - bit 3: timer 1
  - bit 4: interrupt 1
  - bit 5: timer 2
  - bit 6: timer 2 external input
  - bit 7: clock output
- R6: The bits of cfgC (word C) enable signals as follows:
  - bit 0: conversion start 0
  - bit 2: second UART
  - bit 3: timer 4
  - bit 4: timer 4 external input
  - bit 5: conversion start 2
  - Bits 1, 6 and 7 have no effect on any output.
- R7: Enabling a serial peripheral (either UART, SPI or I2C) gives pins to all of its signals together.
- R8: With spiThreeWire high, the SPI slave select (code 5) gets no pin and takes no place in the packing.
- R9: A capture/compare count field N enables channels 0 to N-1. Values 7 and above act as 6.
- R10: A disabled signal has sigValid low and sigPin 0, and its periphIn reads 1 whatever the pins carry.
- R11: A pin with no signal reports code 31 in pinCode and drives 1 on pinOut.
- R12: A pin owned by signal s reports code s, and pinOut on that pin equals periphOut[s].
- R13: For a valid signal s, periphIn[s] equals pinIn at index sigPin[s].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgA | input | 8 | Configuration word A |
| cfgB | input | 8 | Configuration word B |
| cfgC | input | 8 | Configuration word C |
| spiThreeWire | input | 1 | SPI runs without slave select |
| periphOut | input | 30 | Output value of each peripheral signal, indexed by code |
| pinIn | input | NPIN | Value present on each pin |
| pinOut | output | NPIN | Value driven onto each pin |
| pinCode | output | NPIN*5 | Per pin, the 5-bit code of the owning signal, or 31 |
| sigPin | output | 30*PIN_W | Per signal, the pin index it received |
| sigValid | output | 30 | Per signal, set when it holds a pin |
| periphIn | output | 30 | Value routed back to each peripheral input |

## Verification
The checks assume the inputs are settled each time the logic is evaluated, and that the pin count is at least the number of signals that can be enabled, so no signal is pushed past the last pin. The stimulus changes inputs only between sample points. It draws all three words at random, which covers capture/compare count values 7 and above and the ignored bits of word C. Directed cases cover: everything off, everything on, the first UART with and without neighbours, and three-wire SPI.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NSIG   = 30;
  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] CODE_NONE = 5'd31;
  localparam int CAP_CH = 6;

  typedef enum logic [CODE_W-1:0] {
    SIG_UA_TX = 5'd0, SIG_UA_RX = 5'd1, SIG_SPI_CLK = 5'd2, SIG_SPI_MISO = 5'd3,
    SIG_SPI_MOSI = 5'd4, SIG_SPI_SEL = 5'd5, SIG_I2C_DAT = 5'd6, SIG_I2C_CLK = 5'd7,
    SIG_UB_TX = 5'd8, SIG_UB_RX = 5'd9, SIG_CAP0 = 5'd10, SIG_CNT_CLK = 5'd16,
    SIG_CMP0 = 5'd17, SIG_CMP1 = 5'd18, SIG_TMR0 = 5'd19, SIG_IRQ0 = 5'd20,
    SIG_TMR1 = 5'd21, SIG_IRQ1 = 5'd22, SIG_TMR2 = 5'd23, SIG_TMR2_EXT = 5'd24,
    SIG_TMR4 = 5'd25, SIG_TMR4_EXT = 5'd26, SIG_CLK_OUT = 5'd27,
    SIG_CONV0 = 5'd28, SIG_CONV2 = 5'd29
  } sig_e;

  typedef struct packed {
    logic [NSIG-1:0] sigEn;
  } xbar_ctrl_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic [7:0] cfgA,
  input  logic [7:0] cfgB,
  input  logic [7:0] cfgC,
  input  logic       spiThreeWire,
  output xbar_ctrl_t ctrl
);
  logic [2:0] capCount;
  logic [NSIG-1:0] en;

  always_comb begin
    capCount = (cfgA[5:3] > 3'd6) ? 3'd6 : cfgA[5:3];
    en = '0;
    en[SIG_UA_TX]    = cfgA[2];
    en[SIG_UA_RX]    = cfgA[2];
    en[SIG_SPI_CLK]  = cfgA[1];
    en[SIG_SPI_MISO] = cfgA[1];
    en[SIG_SPI_MOSI] = cfgA[1];
    en[SIG_SPI_SEL]  = cfgA[1] & ~spiThreeWire;
    en[SIG_I2C_DAT]  = cfgA[0];
    en[SIG_I2C_CLK]  = cfgA[0];
    en[SIG_UB_TX]    = cfgC[2];
    en[SIG_UB_RX]    = cfgC[2];
    en[SIG_CNT_CLK]  = cfgA[6];
    en[SIG_CMP0]     = cfgA[7];
    en[SIG_CMP1]     = cfgB[0];
    en[SIG_TMR0]     = cfgB[1];
    en[SIG_IRQ0]     = cfgB[2];
    en[SIG_TMR1]     = cfgB[3];
    en[SIG_IRQ1]     = cfgB[4];
    en[SIG_TMR2]     = cfgB[5];
    en[SIG_TMR2_EXT] = cfgB[6];
    en[SIG_CLK_OUT]  = cfgB[7];
    en[SIG_TMR4]     = cfgC[3];
    en[SIG_TMR4_EXT] = cfgC[4];
    en[SIG_CONV0]    = cfgC[0];
    en[SIG_CONV2]    = cfgC[5];
  end

  for (genvar k = 0; k < CAP_CH; k++) begin : g_cap
    assign ctrl.sigEn[int'(SIG_CAP0) + k] = (3'(k) < capCount);
  end

  for (genvar s = 0; s < NSIG; s++) begin : g_pass
    if (s < int'(SIG_CAP0) || s >= int'(SIG_CAP0) + CAP_CH) begin : g_cp
      assign ctrl.sigEn[s] = en[s];
    end
  end

  always_comb begin
    // R9
    cap_contig_chk: assert (!(ctrl.sigEn[int'(SIG_CAP0)+1] && !ctrl.sigEn[int'(SIG_CAP0)]))
      else $error("capture channel enabled without channel 0");
    // R8
    sel_needs_clk_chk: assert (!ctrl.sigEn[SIG_SPI_SEL] || ctrl.sigEn[SIG_SPI_CLK])
      else $error("slave select enabled without SPI");
    // R7
    uart_pair_chk: assert (ctrl.sigEn[SIG_UA_TX] == ctrl.sigEn[SIG_UA_RX])
      else $error("first UART split");
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
#(
  parameter int NPIN  = 32,
  parameter int PIN_W = $clog2(NPIN)
)(
  input  xbar_ctrl_t             ctrl,
  input  logic [NSIG-1:0]        periphOut,
  input  logic [NPIN-1:0]        pinIn,
  output logic [NPIN-1:0]        pinOut,
  output logic [NPIN*CODE_W-1:0] pinCode,
  output logic [NSIG*PIN_W-1:0]  sigPin,
  output logic [NSIG-1:0]        sigValid,
  output logic [NSIG-1:0]        periphIn
);
  logic [PIN_W-1:0]  pos [NSIG];
  logic [CODE_W-1:0] code [NPIN];

  always_comb begin
    int cnt;
    cnt = 0;
    for (int s = 0; s < NSIG; s++) begin
      sigValid[s] = ctrl.sigEn[s] && (cnt < NPIN);
      pos[s] = sigValid[s] ? PIN_W'(cnt) : '0;
      if (ctrl.sigEn[s]) cnt++;
    end
  end

  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      code[p] = CODE_NONE;
      for (int s = 0; s < NSIG; s++)
        if (sigValid[s] && int'(pos[s]) == p) code[p] = CODE_W'(s);
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    assign pinCode[p*CODE_W +: CODE_W] = code[p];
    assign pinOut[p] = (code[p] == CODE_NONE) ? 1'b1 : periphOut[code[p]];
  end

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    assign sigPin[s*PIN_W +: PIN_W] = pos[s];
    assign periphIn[s] = sigValid[s] ? pinIn[pos[s]] : 1'b1;
  end

  always_comb begin
    for (int s = 0; s < NSIG; s++) begin
      // R12
      owner_match_chk: assert (!sigValid[s] || int'(code[pos[s]]) == s)
        else $error("pin of signal %0d names another owner", s);
      // R10
      disabled_idle_chk: assert (sigValid[s] || periphIn[s])
        else $error("unrouted input %0d not high", s);
    end
    for (int p = 0; p < NPIN; p++) begin
      // R11
      free_pin_high_chk: assert (code[p] != CODE_NONE || pinOut[p])
        else $error("free pin %0d not high", p);
      // R1
      no_gap_chk: assert (p == 0 || code[p] == CODE_NONE || code[p-1] != CODE_NONE)
        else $error("gap before pin %0d", p);
      if (p > 0 && code[p] != CODE_NONE && code[p-1] != CODE_NONE) begin
        // R1
        order_chk: assert (code[p-1] < code[p])
          else $error("priority order broken at pin %0d", p);
      end
    end
  end
endmodule

// File: rtl/xbar_top.sv
module xbar_top
  import xbar_pkg::*;
#(
  parameter int NPIN  = 32,
  parameter int PIN_W = $clog2(NPIN)
)(
  input  logic [7:0]             cfgA,
  input  logic [7:0]             cfgB,
  input  logic [7:0]             cfgC,
  input  logic                   spiThreeWire,
  input  logic [NSIG-1:0]        periphOut,
  input  logic [NPIN-1:0]        pinIn,
  output logic [NPIN-1:0]        pinOut,
  output logic [NPIN*CODE_W-1:0] pinCode,
  output logic [NSIG*PIN_W-1:0]  sigPin,
  output logic [NSIG-1:0]        sigValid,
  output logic [NSIG-1:0]        periphIn
);
  xbar_ctrl_t ctrl;

  xbar_ctrl u_ctrl (
    .cfgA(cfgA), .cfgB(cfgB), .cfgC(cfgC),
    .spiThreeWire(spiThreeWire), .ctrl(ctrl)
  );

  xbar_alloc #(.NPIN(NPIN), .PIN_W(PIN_W)) u_alloc (
    .ctrl(ctrl), .periphOut(periphOut), .pinIn(pinIn), .pinOut(pinOut),
    .pinCode(pinCode), .sigPin(sigPin), .sigValid(sigValid), .periphIn(periphIn)
  );
endmodule

// File: tb/sim_xbar_top.sv
module sim_xbar_top;
  localparam int NS = 30;
  localparam int NP = 32;
  localparam int PW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] cfgA, cfgB, cfgC;
  logic spiThreeWire;
  logic [NS-1:0] periphOut, sigValid, periphIn;
  logic [NP-1:0] pinIn, pinOut;
  logic [NP*5-1:0] pinCode;
  logic [NS*PW-1:0] sigPin;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  xbar_top u0 (.*);

  function automatic logic [NS-1:0] wanted(input logic [7:0] a, b, c, input logic tw);
    logic [NS-1:0] e;
    int n;
    e = '0;
    e[0] = a[2]; e[1] = a[2];
    e[2] = a[1]; e[3] = a[1]; e[4] = a[1]; e[5] = a[1] && !tw;
    e[6] = a[0]; e[7] = a[0];
    e[8] = c[2]; e[9] = c[2];
    n = int'(a[5:3]); if (n > 6) n = 6;
    for (int k = 0; k < 6; k++) e[10+k] = (k < n);
    e[16] = a[6]; e[17] = a[7];
    for (int k = 0; k < 7; k++) e[18+k] = b[k];
    e[25] = c[3]; e[26] = c[4]; e[27] = b[7]; e[28] = c[0]; e[29] = c[5];
    return e;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [7:0] a, b, c, input logic tw);
    logic [NS-1:0] e;
    int expPin [NS];
    int expCode [NP];
    int cnt;
    bit pinOk, sigOk, outOk, inOk, freeOk;
    cfgA = a; cfgB = b; cfgC = c; spiThreeWire = tw;
    periphOut = NS'($urandom); pinIn = $urandom;
    @(negedge clk);
    e = wanted(a, b, c, tw);
    for (int p = 0; p < NP; p++) expCode[p] = 31;
    cnt = 0;
    for (int s = 0; s < NS; s++) begin
      expPin[s] = -1;
      if (e[s]) begin expPin[s] = cnt; expCode[cnt] = s; cnt++; end
    end
    pinOk = 1; sigOk = 1; outOk = 1; inOk = 1; freeOk = 1;
    for (int p = 0; p < NP; p++) begin
      if (int'(pinCode[p*5 +: 5]) != expCode[p]) pinOk = 0;
      if (expCode[p] == 31) begin
        if (pinOut[p] !== 1'b1) freeOk = 0;
      end else if (pinOut[p] !== periphOut[expCode[p]]) outOk = 0;
    end
    for (int s = 0; s < NS; s++) begin
      if (expPin[s] < 0) begin
        if (sigValid[s] || sigPin[s*PW +: PW] != 0 || periphIn[s] !== 1'b1) sigOk = 0;
      end else begin
        if (!sigValid[s] || int'(sigPin[s*PW +: PW]) != expPin[s]) sigOk = 0;
        if (periphIn[s] !== pinIn[expPin[s]]) inOk = 0;
      end
    end
    check("R1/R3 pin codes", int'(pinOk), 1);
    check("R1/R4/R5/R6 signal pins (R9 R8 R7)", int'(sigOk), 1);
    check("R10 disabled inputs/valid", int'(sigOk), 1);
    check("R11 free pins", int'(freeOk), 1);
    check("R12 output routing", int'(outOk), 1);
    check("R13 input routing", int'(inOk), 1);
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NP*5-1:0] refCode;
    logic [NS-1:0] refValid;
    void'($urandom(32'd7531));
    // all off: every pin free
    apply_and_check(8'h00, 8'h00, 8'h00, 1'b0);
    check("R11 idle pin 0 code", int'(pinCode[4:0]), 31);
    // R2: first UART alone and with everything on
    apply_and_check(8'h04, 8'h00, 8'h00, 1'b0);
    check("R2 tx on pin0", int'(sigPin[0 +: PW]), 0);
    check("R2 rx on pin1", int'(sigPin[PW +: PW]), 1);
    apply_and_check(8'hFF, 8'hFF, 8'hFF, 1'b0);
    check("R2 tx pin0 full", int'(pinCode[4:0]), 0);
    check("R2 rx pin1 full", int'(pinCode[9:5]), 1);
    check("R9 count 7 gives 6 channels", int'(sigValid[15]), 1);
    // R8: three-wire SPI drops select, I2C data moves to pin 3
    apply_and_check(8'h03, 8'h00, 8'h00, 1'b1);
    check("R8 select not valid", int'(sigValid[5]), 0);
    check("R8 i2c data at pin 3", int'(sigPin[6*PW +: PW]), 3);
    apply_and_check(8'h03, 8'h00, 8'h00, 1'b0);
    check("R7 four-wire select at pin 3", int'(sigPin[5*PW +: PW]), 3);
    // R6: ignored bits of word C
    apply_and_check(8'h2A, 8'h5A, 8'h3D, 1'b0);
    refCode = pinCode; refValid = sigValid;
    apply_and_check(8'h2A, 8'h5A, 8'hFF, 1'b0);
    check("R6 ignored bits keep codes", int'(pinCode == refCode), 1);
    check("R6 ignored bits keep valid", int'(sigValid == refValid), 1);
    // R9: count field sweep
    for (int n = 0; n < 8; n++) begin
      apply_and_check(8'(n << 3), 8'h00, 8'h00, 1'b0);
      check("R9 channel count", $countones(sigValid), (n > 6) ? 6 : n);
    end
    // random mix
    for (int i = 0; i < 400; i++)
      apply_and_check(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule